// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt requests from peripherals on levels 1 to 15 and hands the most urgent one to a processor. Each level has a pending bit, which a one-cycle request pulse sets, a mask bit and a software force bit. A level is active when it is pending or forced and not masked. Level 0 never takes part. The controller presents the highest active level that has not yet been handed over, as a registered level code with a valid strobe. The processor later acknowledges a level, and that acknowledge lets the level be presented again.

A small register port lets software write the mask and force registers and read back pending, mask and force. A test-mode input makes an acknowledge clear the forced copy of a request instead of its pending bit, so that forced interrupts can be exercised without disturbing real peripheral requests.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A level is active when (pending OR force) AND NOT mask holds for it. Level 0 is never active: a request pulse on bit 0 and force-write bit 0 are both dropped, and pending bit 0 and force bit 0 always read 0.
- R2: Among the active levels that are not held as already presented, the controller presents the highest, as irq_lvl_o with irq_valid_o high. irq_lvl_o is 0 whenever irq_valid_o is low.
- R3: Mask reads 0x7FFE after reset. A mask write stores only bits 14 down to 1, so level 15 can never be masked.
- R4: A force write stores bits 15 down to 1 of the write data. Force reads 0 after reset.
- R5: An acknowledge of level N clears force bit N when test_mode_i is 1 and force bit N is set. In every other case it clears pending bit N and leaves force unchanged.
- R6: A presented level is not presented again until it has been acknowledged. Each presentation therefore lasts one cycle, and lower active levels follow in the cycles after it. After the acknowledge, a level that is still active is presented again.
- R7: A pulse on req_i bit N (N from 1 to 15) sets pending bit N.
- R8: When a request pulse and an acknowledge hit the same level in the same cycle, the pending bit ends up set.
- R9: irq_valid_o and irq_lvl_o are registered. A register write or request taken at a rising edge shows at the outputs after the following rising edge, and not before.
- R10: reg_rdata_o is combinational from reg_sel_i, with 0 = pending, 1 = mask, 2 = force and 3 = all zeros. Writes with reg_sel_i set to 0 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Request set pulses, one bit per level |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 pending, 1 mask, 2 force) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| test_mode_i | input | 1 | Acknowledge clears force instead of pending |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | 4 | Level being acknowledged |
| irq_valid_o | output | 1 | New request presented |
| irq_lvl_o | output | 4 | Presented level |

## Verification
The bench builds the block with its default of 16 levels. With that setting the full mask and force registers are 16 bits wide, and a swept set of 4096 mask and force combinations spreads over the whole space. For each combination the bench checks the highest unmasked level and the next-lower level that follows it one cycle later. Directed sequences then cover the acknowledge paths in and out of test mode, the request-and-acknowledge collision, re-presentation after acknowledge, the unmaskable top level and the dropped level 0.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_FORCE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NUM_LEVELS = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  we_i,
  input  irq_pkg::reg_sel_e     sel_i,
  input  logic [NUM_LEVELS-1:0] wdata_i,
  input  logic                  test_mode_i,
  input  logic                  ack_i,
  input  logic [LW-1:0]         ack_lvl_i,
  output logic [NUM_LEVELS-1:0] pend_o,
  output logic [NUM_LEVELS-1:0] mask_o,
  output logic [NUM_LEVELS-1:0] force_o
);
  import irq_pkg::*;

  localparam logic [NUM_LEVELS-1:0] LVL_KEEP  = {{(NUM_LEVELS-1){1'b1}}, 1'b0};
  localparam logic [NUM_LEVELS-1:0] MASK_KEEP = {1'b0, {(NUM_LEVELS-2){1'b1}}, 1'b0};

  logic [NUM_LEVELS-1:0] pend_q, mask_q, force_q;
  logic [NUM_LEVELS-1:0] ack_vec, force_clr, pend_clr;

  assign ack_vec   = ack_i ? (NUM_LEVELS'(1) << ack_lvl_i) : '0;
  // test mode redirects the clear to force only when that force bit is set
  assign force_clr = ack_vec & force_q & {NUM_LEVELS{test_mode_i}};
  assign pend_clr  = ack_vec & ~force_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      mask_q  <= MASK_KEEP;
      force_q <= '0;
    end else begin
      pend_q <= ((pend_q & ~pend_clr) | req_i) & LVL_KEEP;
      if (we_i && sel_i == SEL_MASK) mask_q <= wdata_i & MASK_KEEP;
      if (we_i && sel_i == SEL_FORCE) force_q <= wdata_i & LVL_KEEP;
      else                            force_q <= force_q & ~force_clr;
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LEVELS = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] vec_i,
  output logic                  valid_o,
  output logic [LW-1:0]         lvl_o
);
  // ascending scan, last hit wins: highest level; bit 0 skipped
  always_comb begin
    valid_o = 1'b0;
    lvl_o   = '0;
    for (int i = 1; i < NUM_LEVELS; i++) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        lvl_o   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_present.sv
module irq_present #(
  parameter int NUM_LEVELS = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] active_i,
  input  logic                  ack_i,
  input  logic [LW-1:0]         ack_lvl_i,
  output logic                  valid_o,
  output logic [LW-1:0]         lvl_o,
  output logic [NUM_LEVELS-1:0] posted_o
);
  logic [NUM_LEVELS-1:0] posted_q, posted_d, cand, ack_vec;
  logic                  enc_valid;
  logic [LW-1:0]         enc_lvl;
  logic                  valid_q;
  logic [LW-1:0]         lvl_q;

  assign cand    = active_i & ~posted_q;
  assign ack_vec = ack_i ? (NUM_LEVELS'(1) << ack_lvl_i) : '0;

  irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
    .vec_i   (cand),
    .valid_o (enc_valid),
    .lvl_o   (enc_lvl)
  );

  // a new posting beats a same-cycle ack of that level
  assign posted_d = (posted_q & ~ack_vec) |
                    (enc_valid ? (NUM_LEVELS'(1) << enc_lvl) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      lvl_q    <= '0;
      posted_q <= '0;
    end else begin
      valid_q  <= enc_valid;
      lvl_q    <= enc_valid ? enc_lvl : '0;
      posted_q <= posted_d;
    end
  end

  assign valid_o  = valid_q;
  assign lvl_o    = lvl_q;
  assign posted_o = posted_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_LEVELS = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  reg_we_i,
  input  logic [1:0]            reg_sel_i,
  input  logic [NUM_LEVELS-1:0] reg_wdata_i,
  output logic [NUM_LEVELS-1:0] reg_rdata_o,
  input  logic                  test_mode_i,
  input  logic                  ack_i,
  input  logic [LW-1:0]         ack_lvl_i,
  output logic                  irq_valid_o,
  output logic [LW-1:0]         irq_lvl_o
);
  import irq_pkg::*;

  reg_sel_e              sel;
  logic [NUM_LEVELS-1:0] pend, mask, frc, active, posted;

  assign sel = reg_sel_e'(reg_sel_i);

  irq_regs #(.NUM_LEVELS(NUM_LEVELS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (reg_we_i),
    .sel_i       (sel),
    .wdata_i     (reg_wdata_i),
    .test_mode_i (test_mode_i),
    .ack_i       (ack_i),
    .ack_lvl_i   (ack_lvl_i),
    .pend_o      (pend),
    .mask_o      (mask),
    .force_o     (frc)
  );

  assign active = (pend | frc) & ~mask;

  irq_present #(.NUM_LEVELS(NUM_LEVELS)) u_pres (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .ack_i     (ack_i),
    .ack_lvl_i (ack_lvl_i),
    .valid_o   (irq_valid_o),
    .lvl_o     (irq_lvl_o),
    .posted_o  (posted)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:  reg_rdata_o = pend;
      SEL_MASK:  reg_rdata_o = mask;
      SEL_FORCE: reg_rdata_o = frc;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int NUM_LEVELS = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_LEVELS-1:0] req_i,
  input logic                  irq_valid_o,
  input logic [LW-1:0]         irq_lvl_o,
  input logic [NUM_LEVELS-1:0] pend,
  input logic [NUM_LEVELS-1:0] mask,
  input logic [NUM_LEVELS-1:0] frc
);
  logic [NUM_LEVELS-1:0] req_lv, act_d;

  assign req_lv = req_i & ~NUM_LEVELS'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_d <= '0;
    else         act_d <= (pend | frc) & ~mask;
  end

  a_r1_no_level0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend[0] && !frc[0]);

  a_r2_presented_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> act_d[irq_lvl_o]);

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> irq_lvl_o == '0);

  a_r3_top_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask[NUM_LEVELS-1] && !mask[0]);

  a_r6_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |=> !(irq_valid_o && irq_lvl_o == $past(irq_lvl_o)));

  a_r7_req_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_lv) |=> ((pend & $past(req_lv)) == $past(req_lv)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .irq_valid_o (irq_valid_o),
  .irq_lvl_o   (irq_lvl_o),
  .pend        (pend),
  .mask        (mask),
  .frc         (frc)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         we = 1'b0;
  logic [1:0]   sel = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         tm = 1'b0;
  logic         ack = 1'b0;
  logic [3:0]   ack_lvl = '0;
  logic         vld;
  logic [3:0]   lvl;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NUM_LEVELS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .test_mode_i(tm), .ack_i(ack),
    .ack_lvl_i(ack_lvl), .irq_valid_o(vld), .irq_lvl_o(lvl)
  );

  task automatic check(input string req_tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  function automatic int highest(input logic [N-1:0] v);
    int h = 0;
    for (int i = 1; i < N; i++) if (v[i]) h = i;
    return h;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [N-1:0] d);
    sel = s;
    #1 d = rdata;
  endtask

  task automatic do_ack(input int l, input logic t);
    ack = 1'b1; ack_lvl = 4'(l); tm = t;
    @(negedge clk);
    ack = 1'b0; tm = 1'b0;
  endtask

  task automatic pulse(input int l);
    req = N'(1) << l;
    @(negedge clk);
    req = '0;
  endtask

  task automatic clear_all();
    wr(2'd2, '0);
    for (int l = 1; l < N; l++) do_ack(l, 1'b0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] d, m, p, a;
    int h1, h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(2'd1, d); check("R3 mask reset", d, 16'h7FFE);
    rd(2'd0, d); check("R7 pending reset", d, 0);
    rd(2'd2, d); check("R4 force reset", d, 0);
    check("R2 valid reset", vld, 0);
    check("R2 lvl reset", lvl, 0);
    rd(2'd3, d); check("R10 sel 3 reads zero", d, 0);

    // sweep mask/force combinations
    for (int i = 0; i < 4096; i++) begin
      m = 16'(i * 16'h01F3);
      p = 16'(i * 16'h9E37);
      wr(2'd1, m);
      wr(2'd2, p);
      a = p & 16'hFFFE & ~(m & 16'h7FFE);
      h1 = highest(a);
      @(negedge clk);
      check("R2 sweep valid", vld, (h1 != 0) ? 1 : 0);
      check("R2 sweep lvl", lvl, h1);
      if (h1 != 0) a[h1] = 1'b0;
      h2 = highest(a);
      @(negedge clk);
      check("R6 sweep next lower", lvl, h2);
      if (i[6:0] == 0) begin
        rd(2'd1, d); check("R3 sweep mask store", d, m & 16'h7FFE);
        rd(2'd2, d); check("R4 sweep force store", d, p & 16'hFFFE);
      end
      clear_all();
    end

    wr(2'd1, '0);
    @(negedge clk);

    // R9 timing
    wr(2'd2, 16'h0080);
    check("R9 not before second edge", vld, 0);
    @(negedge clk);
    check("R9 valid after second edge", vld, 1);
    check("R9 lvl", lvl, 7);
    clear_all();

    // R7 / R10 / R6 request path
    pulse(5);
    rd(2'd0, d); check("R7 pending set", d, 16'h0020);
    check("R10 pending read", d, 16'h0020);
    @(negedge clk);
    check("R7 presented", lvl, 5);
    @(negedge clk);
    check("R6 not repeated", vld, 0);
    do_ack(5, 1'b0);
    rd(2'd0, d); check("R5 ack clears pending", d, 0);
    @(negedge clk);
    check("R6 cleared level not presented", vld, 0);

    // R8 collision
    pulse(6);
    repeat (2) @(negedge clk);
    req = N'(1) << 6; ack = 1'b1; ack_lvl = 4'd6;
    @(negedge clk);
    req = '0; ack = 1'b0;
    rd(2'd0, d); check("R8 set wins over ack", d, 16'h0040);
    do_ack(6, 1'b0);
    rd(2'd0, d); check("R8 later ack clears", d, 0);
    clear_all();

    // R5 test mode with force set
    wr(2'd2, 16'h0200);
    pulse(9);
    do_ack(9, 1'b1);
    rd(2'd2, d); check("R5 tm clears force", d, 0);
    rd(2'd0, d); check("R5 tm keeps pending", d, 16'h0200);
    do_ack(9, 1'b1);
    rd(2'd0, d); check("R5 tm without force clears pending", d, 0);
    clear_all();

    // R5 normal ack with force set, R6 re-presentation
    wr(2'd2, 16'h0008);
    pulse(3);
    repeat (3) @(negedge clk);
    do_ack(3, 1'b0);
    rd(2'd0, d); check("R5 normal ack clears pending", d, 0);
    rd(2'd2, d); check("R5 normal ack keeps force", d, 16'h0008);
    @(negedge clk);
    check("R6 re-presented valid", vld, 1);
    check("R6 re-presented lvl", lvl, 3);
    clear_all();

    // R3 unmaskable top level
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R3 mask keeps 14..1", d, 16'h7FFE);
    wr(2'd2, 16'hC000);
    @(negedge clk);
    check("R3 level 15 through full mask", lvl, 15);
    @(negedge clk);
    check("R3 level 14 masked", vld, 0);
    clear_all();
    wr(2'd1, '0);

    // R1 level 0 dropped, R10 ignored writes
    pulse(0);
    rd(2'd0, d); check("R1 req 0 dropped", d, 0);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); check("R1 force bit 0 dropped", d, 0);
    @(negedge clk);
    check("R1 nothing presented", vld, 0);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R10 pending write ignored", d, 0);
    wr(2'd3, 16'hFFFF);
    rd(2'd1, d); check("R10 sel 3 write ignored mask", d, 0);
    rd(2'd2, d); check("R10 sel 3 write ignored force", d, 0);

    summary();
    $finish;
  end
endmodule